// File: doc/BRIEF.md
# Dual 16-bit Cascadable Adder/Accumulator

This block is the add/accumulate back end of a configurable arithmetic slice. It holds two 16-bit adder/subtractor units, called top and bottom. Each unit adds a selected first operand to a selected second operand, plus a selected carry. The first operand is a data port, a product from an external multiplier, or a replicated sign bit. The second operand is either the unit's own accumulator register or a preload port. An accumulator register can be cleared, preloaded, held or updated with the sum, and it can drive the output. The carry out of the bottom unit can feed the top unit's carry-in, so the pair works as one 32-bit adder or accumulator.

The operand, carry and output choices are fixed per instance through parameters. The run-time controls are the clock enable, clears, loads, holds and add/subtract. The multiplier that produces the product inputs sits outside the block. Cascade ports let several slices be chained into wider adders.

Top module: `dual_acc16`

## Requirements
- R1: A high `accRstTop`/`accRstBot` on an enabled edge clears that half's accumulator. This clear wins over load and hold. The clear acts only on enabled edges.
- R2: When not cleared, a high load on an enabled edge copies the preload value (`preC` for top, `preD` for bottom) into the accumulator, even when hold is high. Otherwise hold=1 keeps the value and hold=0 stores the sum.
- R3: With `clkEn` low, no register in the block changes.
- R4: In the default configuration the pair is a 32-bit accumulator of {`opA`,`opB`}. The top carry-in comes from the bottom carry-out. With both subtract controls high the pair subtracts in 32-bit two's complement.
- R5: Top first operand select `TOP_X_SEL`: 0 = `opA`, 1 = `prodTop8`, 2 = `prodFull[31:16]`, 3 = bit 15 of the bottom first operand (taken before any inversion) replicated 16 times.
- R6: Bottom first operand select `BOT_X_SEL`: 0 = `opB`, 1 = `prodBot8`, 2 = `prodFull[15:0]`, 3 = `signExtIn` replicated 16 times.
- R7: Second operand select `*_W_SEL`: 0 = the half's accumulator, 1 = its preload value (top `preC`, bottom `preD`).
- R8: Each half computes W + X + cin, or W + ~X + cin when its subtract control is 1. Carry select code 0 gives cin = subtract and code 1 gives cin = NOT subtract. For the top half, codes 2 and 3 give the bottom carry-out. For the bottom half, code 2 gives `accCarryIn` and code 3 gives `carryIn`.
- R9: Output select per half: 0 = unregistered sum, 1 = accumulator register, 2 = that half's 8x8 product port, 3 = that half's 16-bit share of `prodFull` (upper to the top output, lower to the bottom output).
- R10: With `*_PRE_REG`=1 the preload path is registered. `inRst*` clears that register. Otherwise, on an enabled edge, hold=0 loads it and hold=1 keeps it.
- R11: `carryOut` is the top carry-out when the top second operand is the preload, else 0. `accCarryOut` is the top carry-out when the top second operand is the accumulator, else 0. `signExtOut` is bit 15 of the top first operand before inversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| clkEn | input | 1 | Enables every register |
| inRstTop | input | 1 | Clears the top preload register |
| inRstBot | input | 1 | Clears the bottom preload register |
| accRstTop | input | 1 | Clears the top accumulator |
| accRstBot | input | 1 | Clears the bottom accumulator |
| holdPreTop | input | 1 | 1 = keep the top preload register |
| holdPreBot | input | 1 | 1 = keep the bottom preload register |
| loadTop | input | 1 | Load the top accumulator from the preload |
| loadBot | input | 1 | Load the bottom accumulator from the preload |
| holdTop | input | 1 | 1 = keep the top accumulator |
| holdBot | input | 1 | 1 = keep the bottom accumulator |
| subTop | input | 1 | 1 = top half subtracts |
| subBot | input | 1 | 1 = bottom half subtracts |
| opA | input | 16 | Top data operand |
| opB | input | 16 | Bottom data operand |
| preC | input | 16 | Top preload / second operand |
| preD | input | 16 | Bottom preload / second operand |
| prodTop8 | input | 16 | Top 8x8 product |
| prodBot8 | input | 16 | Bottom 8x8 product |
| prodFull | input | 32 | 16x16 product |
| carryIn | input | 1 | Adder carry from the previous slice |
| accCarryIn | input | 1 | Accumulator carry from the previous slice |
| signExtIn | input | 1 | Sign bit from the previous slice |
| result | output | 32 | {top output, bottom output} |
| carryOut | output | 1 | Adder-mode carry to the next slice |
| accCarryOut | output | 1 | Accumulate-mode carry to the next slice |
| signExtOut | output | 1 | Sign bit to the next slice |

## Verification
The bench targets the low-half rollover, such as 0x0000FFFF + 1 and the matching subtract back across the boundary. A design that drops the chained carry, or applies the subtract carry wrongly, leaves the top half off by one. Sign-extension sweeps use the values 0x7FFF, 0x8000 and 0xFFFF with both subtract settings and both carry-in values; a wrong sign source or a misplaced inversion corrupts the upper 16 bits and the 32-bit carry. Random control mixes combine clear, load and hold in the same cycle. A wrong priority shows up as a stale or unexpected preload. An ungated register shows up as a change while the clock enable is low.

// File: rtl/dacc_pkg.sv
package dacc_pkg;
  // per-half strobes from control to datapath
  typedef struct packed {
    logic accClr;
    logic accLoad;
    logic accSum;
    logic inClr;
    logic inLoad;
    logic negate;
  } halfStrobe_t;

  localparam logic [1:0] XSRC_PORT   = 2'd0;
  localparam logic [1:0] XSRC_PROD8  = 2'd1;
  localparam logic [1:0] XSRC_PROD16 = 2'd2;
  localparam logic [1:0] XSRC_SIGN   = 2'd3;

  localparam logic WSRC_ACC = 1'b0;
  localparam logic WSRC_PRE = 1'b1;

  localparam logic [1:0] CIN_ZERO   = 2'd0;
  localparam logic [1:0] CIN_ONE    = 2'd1;
  localparam logic [1:0] CIN_CASC_A = 2'd2;
  localparam logic [1:0] CIN_CASC_B = 2'd3;

  localparam logic [1:0] OUT_SUM    = 2'd0;
  localparam logic [1:0] OUT_ACC    = 2'd1;
  localparam logic [1:0] OUT_PROD8  = 2'd2;
  localparam logic [1:0] OUT_PROD16 = 2'd3;
endpackage

// File: rtl/dacc_ctrl.sv
module dacc_ctrl
  import dacc_pkg::*;
#(
  parameter int NUM_HALVES = 2
) (
  input  logic                    clkEn,
  input  logic [NUM_HALVES-1:0]   accRst,
  input  logic [NUM_HALVES-1:0]   load,
  input  logic [NUM_HALVES-1:0]   hold,
  input  logic [NUM_HALVES-1:0]   inRst,
  input  logic [NUM_HALVES-1:0]   inHold,
  input  logic [NUM_HALVES-1:0]   sub,
  output halfStrobe_t [NUM_HALVES-1:0] strobe
);
  // priority: clear, then load, then hold, then accumulate; all behind clkEn
  for (genvar h = 0; h < NUM_HALVES; h++) begin : g_half
    assign strobe[h] = '{
      accClr:  clkEn & accRst[h],
      accLoad: clkEn & ~accRst[h] & load[h],
      accSum:  clkEn & ~accRst[h] & ~load[h] & ~hold[h],
      inClr:   clkEn & inRst[h],
      inLoad:  clkEn & ~inRst[h] & ~inHold[h],
      negate:  sub[h]
    };
  end
endmodule

// File: rtl/dacc_half.sv
module dacc_half
  import dacc_pkg::*;
#(
  parameter int         W       = 16,
  parameter logic [1:0] X_SEL   = XSRC_PORT,
  parameter logic       W_SEL   = WSRC_ACC,
  parameter logic [1:0] CIN_SEL = CIN_ZERO,
  parameter logic [1:0] OUT_SEL = OUT_ACC,
  parameter bit         PRE_REG = 1'b0
) (
  input  logic        clk,
  input  halfStrobe_t strobe,
  input  logic [W-1:0] portX,
  input  logic [W-1:0] prod8,
  input  logic [W-1:0] prodPart,
  input  logic [W-1:0] preIn,
  input  logic        signSrc,
  input  logic        cascA,
  input  logic        cascB,
  output logic [W-1:0] outVal,
  output logic        carry,
  output logic        xMsb
);
  logic [W-1:0] preVal;
  logic [W-1:0] xVal;
  logic [W-1:0] xEff;
  logic [W-1:0] wVal;
  logic [W-1:0] accQ;
  logic [W:0]   fullSum;
  logic         cin;

  if (PRE_REG) begin : g_pre_reg
    logic [W-1:0] preQ;
    always_ff @(posedge clk) begin
      if (strobe.inClr)       preQ <= '0;
      else if (strobe.inLoad) preQ <= preIn;
    end
    assign preVal = preQ;
  end else begin : g_pre_wire
    logic unusedPre;
    assign unusedPre = strobe.inClr ^ strobe.inLoad;
    assign preVal = preIn;
  end

  always_comb begin
    case (X_SEL)
      XSRC_PORT:   xVal = portX;
      XSRC_PROD8:  xVal = prod8;
      XSRC_PROD16: xVal = prodPart;
      default:     xVal = {W{signSrc}};
    endcase
  end

  assign xMsb = xVal[W-1];
  assign xEff = strobe.negate ? ~xVal : xVal;
  assign wVal = (W_SEL == WSRC_PRE) ? preVal : accQ;

  always_comb begin
    case (CIN_SEL)
      CIN_ZERO:   cin = strobe.negate;
      CIN_ONE:    cin = ~strobe.negate;
      CIN_CASC_A: cin = cascA;
      default:    cin = cascB;
    endcase
  end

  assign fullSum = {1'b0, wVal} + {1'b0, xEff} + {{W{1'b0}}, cin};
  assign carry   = fullSum[W];

  always_ff @(posedge clk) begin
    if (strobe.accClr)       accQ <= '0;
    else if (strobe.accLoad) accQ <= preVal;
    else if (strobe.accSum)  accQ <= fullSum[W-1:0];
  end

  always_comb begin
    case (OUT_SEL)
      OUT_SUM:   outVal = fullSum[W-1:0];
      OUT_ACC:   outVal = accQ;
      OUT_PROD8: outVal = prod8;
      default:   outVal = prodPart;
    endcase
  end
endmodule

// File: rtl/dual_acc16.sv
module dual_acc16
  import dacc_pkg::*;
#(
  parameter int         HALF_W      = 16,
  parameter logic [1:0] TOP_X_SEL   = XSRC_PORT,
  parameter logic [1:0] BOT_X_SEL   = XSRC_PORT,
  parameter logic       TOP_W_SEL   = WSRC_ACC,
  parameter logic       BOT_W_SEL   = WSRC_ACC,
  parameter logic [1:0] TOP_CIN_SEL = CIN_CASC_A,
  parameter logic [1:0] BOT_CIN_SEL = CIN_ZERO,
  parameter logic [1:0] TOP_OUT_SEL = OUT_ACC,
  parameter logic [1:0] BOT_OUT_SEL = OUT_ACC,
  parameter bit         TOP_PRE_REG = 1'b0,
  parameter bit         BOT_PRE_REG = 1'b0,
  localparam int        FULL_W      = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              clkEn,
  input  logic              inRstTop,
  input  logic              inRstBot,
  input  logic              accRstTop,
  input  logic              accRstBot,
  input  logic              holdPreTop,
  input  logic              holdPreBot,
  input  logic              loadTop,
  input  logic              loadBot,
  input  logic              holdTop,
  input  logic              holdBot,
  input  logic              subTop,
  input  logic              subBot,
  input  logic [HALF_W-1:0] opA,
  input  logic [HALF_W-1:0] opB,
  input  logic [HALF_W-1:0] preC,
  input  logic [HALF_W-1:0] preD,
  input  logic [HALF_W-1:0] prodTop8,
  input  logic [HALF_W-1:0] prodBot8,
  input  logic [FULL_W-1:0] prodFull,
  input  logic              carryIn,
  input  logic              accCarryIn,
  input  logic              signExtIn,
  output logic [FULL_W-1:0] result,
  output logic              carryOut,
  output logic              accCarryOut,
  output logic              signExtOut
);
  halfStrobe_t [1:0] strobe;   // index 1 = top, 0 = bottom
  logic [HALF_W-1:0] topOut, botOut;
  logic topCarry, botCarry, topXMsb, botXMsb;

  dacc_ctrl #(.NUM_HALVES(2)) u_ctrl (
    .clkEn  (clkEn),
    .accRst ({accRstTop, accRstBot}),
    .load   ({loadTop, loadBot}),
    .hold   ({holdTop, holdBot}),
    .inRst  ({inRstTop, inRstBot}),
    .inHold ({holdPreTop, holdPreBot}),
    .sub    ({subTop, subBot}),
    .strobe (strobe)
  );

  dacc_half #(
    .W(HALF_W), .X_SEL(BOT_X_SEL), .W_SEL(BOT_W_SEL),
    .CIN_SEL(BOT_CIN_SEL), .OUT_SEL(BOT_OUT_SEL), .PRE_REG(BOT_PRE_REG)
  ) u_bot (
    .clk      (clk),
    .strobe   (strobe[0]),
    .portX    (opB),
    .prod8    (prodBot8),
    .prodPart (prodFull[HALF_W-1:0]),
    .preIn    (preD),
    .signSrc  (signExtIn),
    .cascA    (accCarryIn),
    .cascB    (carryIn),
    .outVal   (botOut),
    .carry    (botCarry),
    .xMsb     (botXMsb)
  );

  dacc_half #(
    .W(HALF_W), .X_SEL(TOP_X_SEL), .W_SEL(TOP_W_SEL),
    .CIN_SEL(TOP_CIN_SEL), .OUT_SEL(TOP_OUT_SEL), .PRE_REG(TOP_PRE_REG)
  ) u_top (
    .clk      (clk),
    .strobe   (strobe[1]),
    .portX    (opA),
    .prod8    (prodTop8),
    .prodPart (prodFull[FULL_W-1:HALF_W]),
    .preIn    (preC),
    .signSrc  (botXMsb),
    .cascA    (botCarry),
    .cascB    (botCarry),
    .outVal   (topOut),
    .carry    (topCarry),
    .xMsb     (topXMsb)
  );

  assign result     = {topOut, botOut};
  assign signExtOut = topXMsb;

  if (TOP_W_SEL == WSRC_PRE) begin : g_adder_casc
    assign carryOut    = topCarry;
    assign accCarryOut = 1'b0;
  end else begin : g_accum_casc
    assign carryOut    = 1'b0;
    assign accCarryOut = topCarry;
  end
endmodule

// File: rtl/dual_acc16_chk.sv
module dual_acc16_chk
  import dacc_pkg::*;
#(
  parameter int         HALF_W      = 16,
  parameter logic [1:0] TOP_OUT_SEL = OUT_ACC,
  parameter logic [1:0] BOT_OUT_SEL = OUT_ACC,
  parameter bit         TOP_PRE_REG = 1'b0,
  parameter bit         BOT_PRE_REG = 1'b0,
  localparam int        FULL_W      = 2 * HALF_W
) (
  input logic              clk,
  input logic              clkEn,
  input logic              accRstTop,
  input logic              accRstBot,
  input logic              loadTop,
  input logic              loadBot,
  input logic              holdTop,
  input logic              holdBot,
  input logic [HALF_W-1:0] preC,
  input logic [HALF_W-1:0] preD,
  input logic [FULL_W-1:0] result
);
  logic armed = 1'b0;
  always_ff @(posedge clk) begin
    if (clkEn && accRstTop && accRstBot) armed <= 1'b1;
  end

  if (TOP_OUT_SEL == OUT_ACC) begin : g_top
    p_clear_top_r1: assert property (@(posedge clk) disable iff (!armed)
      clkEn && accRstTop |=> result[FULL_W-1:HALF_W] == '0)
      else $error("top accumulator not cleared");
    p_hold_top_r2: assert property (@(posedge clk) disable iff (!armed)
      clkEn && !accRstTop && !loadTop && holdTop |=> $stable(result[FULL_W-1:HALF_W]))
      else $error("top accumulator moved while held");
    if (!TOP_PRE_REG) begin : g_load
      p_load_top_r2: assert property (@(posedge clk) disable iff (!armed)
        clkEn && !accRstTop && loadTop |=> result[FULL_W-1:HALF_W] == $past(preC))
        else $error("top preload not taken");
    end
  end

  if (BOT_OUT_SEL == OUT_ACC) begin : g_bot
    p_clear_bot_r1: assert property (@(posedge clk) disable iff (!armed)
      clkEn && accRstBot |=> result[HALF_W-1:0] == '0)
      else $error("bottom accumulator not cleared");
    p_hold_bot_r2: assert property (@(posedge clk) disable iff (!armed)
      clkEn && !accRstBot && !loadBot && holdBot |=> $stable(result[HALF_W-1:0]))
      else $error("bottom accumulator moved while held");
    if (!BOT_PRE_REG) begin : g_load
      p_load_bot_r2: assert property (@(posedge clk) disable iff (!armed)
        clkEn && !accRstBot && loadBot |=> result[HALF_W-1:0] == $past(preD))
        else $error("bottom preload not taken");
    end
  end

  if (TOP_OUT_SEL == OUT_ACC && BOT_OUT_SEL == OUT_ACC) begin : g_freeze
    p_freeze_r3: assert property (@(posedge clk) disable iff (!armed)
      !clkEn |=> $stable(result))
      else $error("registers changed with clock enable low");
  end
endmodule

bind dual_acc16 dual_acc16_chk #(
  .HALF_W(HALF_W), .TOP_OUT_SEL(TOP_OUT_SEL), .BOT_OUT_SEL(BOT_OUT_SEL),
  .TOP_PRE_REG(TOP_PRE_REG), .BOT_PRE_REG(BOT_PRE_REG)
) u_chk (
  .clk(clk), .clkEn(clkEn), .accRstTop(accRstTop), .accRstBot(accRstBot),
  .loadTop(loadTop), .loadBot(loadBot), .holdTop(holdTop), .holdBot(holdBot),
  .preC(preC), .preD(preD), .result(result)
);

// File: tb/tb_dual_acc16.sv
`timescale 1ns/1ps
module tb_dual_acc16;
  import dacc_pkg::*;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic clkEn, inRstTop, inRstBot, accRstTop, accRstBot, holdPreTop, holdPreBot;
  logic loadTop, loadBot, holdTop, holdBot, subTop, subBot;
  logic [15:0] opA, opB, preC, preD, prodTop8, prodBot8;
  logic [31:0] prodFull;
  logic carryIn, accCarryIn, signExtIn;

  logic [31:0] resD, resX, resM, resP;
  logic coD, acoD, sxD, coX, acoX, sxX, coM, acoM, sxM, coP, acoP, sxP;

  int nChecks = 0;
  int nFail = 0;
  logic [15:0] refHi, refLo, cReg, dReg;
  logic [16:0] tF, bF;
  logic [32:0] e33;
  logic [31:0] sx32, held;

  // default: 32-bit chained accumulator of {opA,opB}
  dual_acc16 dut (
    .clk, .clkEn, .inRstTop, .inRstBot, .accRstTop, .accRstBot, .holdPreTop, .holdPreBot,
    .loadTop, .loadBot, .holdTop, .holdBot, .subTop, .subBot, .opA, .opB, .preC, .preD,
    .prodTop8, .prodBot8, .prodFull, .carryIn, .accCarryIn, .signExtIn,
    .result(resD), .carryOut(coD), .accCarryOut(acoD), .signExtOut(sxD));

  // 32-bit adder: {C,D} registered + sign-extended opB
  dual_acc16 #(.TOP_X_SEL(XSRC_SIGN), .BOT_X_SEL(XSRC_PORT), .TOP_W_SEL(WSRC_PRE),
    .BOT_W_SEL(WSRC_PRE), .TOP_CIN_SEL(CIN_CASC_B), .BOT_CIN_SEL(CIN_CASC_B),
    .TOP_OUT_SEL(OUT_SUM), .BOT_OUT_SEL(OUT_SUM), .TOP_PRE_REG(1'b1), .BOT_PRE_REG(1'b1)) dutX (
    .clk, .clkEn, .inRstTop, .inRstBot, .accRstTop, .accRstBot, .holdPreTop, .holdPreBot,
    .loadTop, .loadBot, .holdTop, .holdBot, .subTop, .subBot, .opA, .opB, .preC, .preD,
    .prodTop8, .prodBot8, .prodFull, .carryIn, .accCarryIn, .signExtIn,
    .result(resX), .carryOut(coX), .accCarryOut(acoX), .signExtOut(sxX));

  // product accumulators with independent halves
  dual_acc16 #(.TOP_X_SEL(XSRC_PROD16), .BOT_X_SEL(XSRC_PROD8), .TOP_CIN_SEL(CIN_ONE),
    .BOT_CIN_SEL(CIN_CASC_A), .TOP_OUT_SEL(OUT_SUM), .BOT_OUT_SEL(OUT_SUM)) dutM (
    .clk, .clkEn, .inRstTop, .inRstBot, .accRstTop, .accRstBot, .holdPreTop, .holdPreBot,
    .loadTop, .loadBot, .holdTop, .holdBot, .subTop, .subBot, .opA, .opB, .preC, .preD,
    .prodTop8, .prodBot8, .prodFull, .carryIn, .accCarryIn, .signExtIn,
    .result(resM), .carryOut(coM), .accCarryOut(acoM), .signExtOut(sxM));

  // product pass-through outputs
  dual_acc16 #(.TOP_X_SEL(XSRC_PROD8), .BOT_X_SEL(XSRC_SIGN), .TOP_CIN_SEL(CIN_CASC_A),
    .BOT_CIN_SEL(CIN_ZERO), .TOP_OUT_SEL(OUT_PROD8), .BOT_OUT_SEL(OUT_PROD16)) dutP (
    .clk, .clkEn, .inRstTop, .inRstBot, .accRstTop, .accRstBot, .holdPreTop, .holdPreBot,
    .loadTop, .loadBot, .holdTop, .holdBot, .subTop, .subBot, .opA, .opB, .preC, .preD,
    .prodTop8, .prodBot8, .prodFull, .carryIn, .accCarryIn, .signExtIn,
    .result(resP), .carryOut(coP), .accCarryOut(acoP), .signExtOut(sxP));

  function automatic logic [16:0] addHalf(logic [15:0] w, logic [15:0] x, logic neg, logic ci);
    return {1'b0, w} + {1'b0, (neg ? ~x : x)} + {16'd0, ci};
  endfunction

  function automatic logic [15:0] nextAcc(logic [15:0] cur, logic rst, logic ld,
                                          logic hd, logic [15:0] pre, logic [15:0] s);
    if (rst) return 16'd0;
    if (ld) return pre;
    if (hd) return cur;
    return s;
  endfunction

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check32(string tag, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check1(string tag, logic act, logic exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    clkEn = 1; inRstTop = 1; inRstBot = 1; accRstTop = 1; accRstBot = 1;
    holdPreTop = 0; holdPreBot = 0; loadTop = 0; loadBot = 0; holdTop = 0; holdBot = 0;
    subTop = 0; subBot = 0; opA = 0; opB = 0; preC = 0; preD = 0;
    prodTop8 = 0; prodBot8 = 0; prodFull = 0; carryIn = 0; accCarryIn = 0; signExtIn = 0;
    tick(); tick();
    inRstTop = 0; inRstBot = 0; accRstTop = 0; accRstBot = 0; holdTop = 1; holdBot = 1;
    #1;
    check32("R1 reset state", resD, 32'h0);

    // R2: load beats hold
    loadTop = 1; loadBot = 1; preC = 16'h1234; preD = 16'h5678;
    tick();
    check32("R2 load over hold", resD, 32'h12345678);
    // R1: clear beats load on top; bottom held
    accRstTop = 1; loadBot = 0; preC = 16'hAAAA;
    tick();
    check32("R1 clear over load", resD, 32'h00005678);
    accRstTop = 0;
    loadTop = 1; loadBot = 1; preC = 16'h0000; preD = 16'hFFFF;
    tick();
    loadTop = 0; loadBot = 0; holdTop = 0; holdBot = 0; opA = 16'h0; opB = 16'h1;
    tick();
    check32("R4 carry into top half", resD, 32'h00010000);
    subTop = 1; subBot = 1;
    tick();
    check32("R4 borrow across halves", resD, 32'h0000FFFF);
    clkEn = 0; subTop = 0; subBot = 0; opB = 16'h0042;
    tick();
    check32("R3 enable low freezes", resD, 32'h0000FFFF);
    clkEn = 1;

    refHi = 16'h0000; refLo = 16'hFFFF;
    for (int i = 0; i < 400; i++) begin
      opA = 16'($urandom); opB = 16'($urandom); preC = 16'($urandom); preD = 16'($urandom);
      subTop = 1'($urandom_range(0, 1)); subBot = 1'($urandom_range(0, 1));
      loadTop = ($urandom_range(0, 7) == 0); loadBot = ($urandom_range(0, 7) == 0);
      holdTop = ($urandom_range(0, 5) == 0); holdBot = ($urandom_range(0, 5) == 0);
      accRstTop = ($urandom_range(0, 19) == 0); accRstBot = ($urandom_range(0, 19) == 0);
      clkEn = ($urandom_range(0, 9) != 0);
      #1;
      bF = addHalf(refLo, opB, subBot, subBot);
      tF = addHalf(refHi, opA, subTop, bF[16]);
      check1("R11 accumulate carry out", acoD, tF[16]);
      check1("R11 adder carry out idle", coD, 1'b0);
      check1("R5 sign out from opA", sxD, opA[15]);
      if (clkEn) begin
        refLo = nextAcc(refLo, accRstBot, loadBot, holdBot, preD, bF[15:0]);
        refHi = nextAcc(refHi, accRstTop, loadTop, holdTop, preC, tF[15:0]);
      end
      tick();
      check32("R4 R2 R1 R3 random accumulate", resD, {refHi, refLo});
    end
    clkEn = 1; accRstTop = 0; accRstBot = 0; loadTop = 0; loadBot = 0;

    // registered preload adder with sign extension
    for (int i = 0; i < 48; i++) begin
      preC = 16'($urandom); preD = 16'($urandom); holdPreTop = 0; holdPreBot = 0;
      tick();
      cReg = preC; dReg = preD;
      holdPreTop = 1; holdPreBot = 1; preC = ~preC; preD = ~preD;
      case (i % 6)
        0: opB = 16'h0000;
        1: opB = 16'h0001;
        2: opB = 16'h7FFF;
        3: opB = 16'h8000;
        4: opB = 16'hFFFF;
        default: opB = 16'($urandom);
      endcase
      subTop = 1'((i / 6) % 2); subBot = subTop; carryIn = 1'((i / 12) % 2);
      #1;
      sx32 = {{16{opB[15]}}, opB};
      e33 = {1'b0, cReg, dReg} + {1'b0, (subTop ? ~sx32 : sx32)} + {32'd0, carryIn};
      check32("R6 R5 R8 sign-extended add", resX, e33[31:0]);
      check1("R11 adder carry out", coX, e33[32]);
      check1("R11 accumulate carry idle", acoX, 1'b0);
      check1("R5 sign out from bottom", sxX, opB[15]);
      held = e33[31:0];
      tick();
      check32("R10 preload register held", resX, held);
    end
    preC = 16'h1357; preD = 16'h2468; holdPreTop = 0; holdPreBot = 0; inRstTop = 1;
    tick();
    inRstTop = 0; holdPreTop = 1; holdPreBot = 1; opB = 0; subTop = 0; subBot = 0; carryIn = 0;
    #1;
    check32("R10 preload register clear", resX, 32'h00002468);

    // product operands, independent halves, accumulate each cycle
    holdTop = 0; holdBot = 0; accRstTop = 1; accRstBot = 1;
    tick();
    accRstTop = 0; accRstBot = 0;
    refHi = 0; refLo = 0;
    for (int i = 0; i < 40; i++) begin
      prodFull = $urandom; prodBot8 = 16'($urandom);
      subTop = 1'($urandom_range(0, 1)); subBot = 1'($urandom_range(0, 1));
      accCarryIn = 1'($urandom_range(0, 1));
      #1;
      tF = addHalf(refHi, prodFull[31:16], subTop, ~subTop);
      bF = addHalf(refLo, prodBot8, subBot, accCarryIn);
      check32("R5 R6 R7 R8 R9 product accumulate", resM, {tF[15:0], bF[15:0]});
      check1("R11 accumulate carry product", acoM, tF[16]);
      check1("R11 adder carry idle product", coM, 1'b0);
      refHi = tF[15:0]; refLo = bF[15:0];
      tick();
    end

    // product outputs; accumulators held at zero
    accRstTop = 1; accRstBot = 1;
    tick();
    accRstTop = 0; accRstBot = 0; holdTop = 1; holdBot = 1;
    for (int i = 0; i < 32; i++) begin
      prodTop8 = (i % 4 == 0) ? 16'hFFFF : 16'($urandom);
      prodFull = $urandom;
      signExtIn = 1'($urandom_range(0, 1));
      subBot = 1'($urandom_range(0, 1)); subTop = 1'($urandom_range(0, 1));
      #1;
      bF = addHalf(16'd0, {16{signExtIn}}, subBot, subBot);
      tF = addHalf(16'd0, prodTop8, subTop, bF[16]);
      check32("R9 product outputs", resP, {prodTop8, prodFull[15:0]});
      check1("R6 R8 sign-in chain carry", acoP, tF[16]);
      check1("R5 sign out from top product", sxP, prodTop8[15]);
      tick();
    end

    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule